// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block is the programmable feedback divider of a frequency synthesizer. It sees a stream of input ticks that a fixed divide-by-8 stage has already produced. For every 32·M+S ticks it emits one single-cycle output pulse, so the overall ratio from the oscillator is 8·(32·M+S). The division is done in two stages. A modelled dual-modulus prescaler counts 33 ticks per sub-cycle while a 5-bit swallow counter is non-zero, and 32 ticks per sub-cycle after it expires. A 10-bit main counter counts the prescaler sub-cycles. When it expires, the output pulse fires and both counters reload.

The divider settings M and S arrive as held parallel values, together with a span flag. The flag selects whether the main counter uses 9 bits or all 10 bits. A load strobe copies these values into shadow registers. The running count reads the shadow values only when a period ends. The tick input is a plain enable, not a data stream. It has no ready signal and no back-pressure: every cycle with the tick high is counted. Cycles with the tick low do not advance the count.

Top module: `pss_divider`

## Requirements
- R1: After reset the shadow settings are M=32 and S=0, and `out_pulse` is low while reset is held. The first output pulse follows the 1024th input tick.
- R2: The block counts exactly 32·M+S input ticks per period. `out_pulse` is high for one cycle, in the cycle after the clock edge that takes in the period's last tick.
- R3: Every S from 0 to 31 is honoured. The prescaler counts 33 ticks in each of the first S sub-cycles of a period and 32 ticks in the remaining ones.
- R4: With `ld_wide`=0 (narrow span), bit 9 of `ld_m` is ignored, and M is the value of bits 8..0.
- R5: With `ld_wide`=1 (wide span), all 10 bits of `ld_m` are used, up to M=1023.
- R6: An effective M below 32, taken after narrow masking, is replaced by 32.
- R7: A load during a period does not alter that period's length. The new values govern the next period.
- R8: When the load strobe falls in the same cycle as the period-ending tick, the reload at that edge uses the previous shadow values. The new values take effect one period later.
- R9: A cycle with `in_tick` low leaves all counting state unchanged.
- R10: `out_pulse` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_tick | input | 1 | One input cycle of the pre-scaled stream when high |
| ld_stb | input | 1 | Copies ld_m, ld_s and ld_wide into the shadow settings |
| ld_m | input | 10 | Main-counter ratio M |
| ld_s | input | 5 | Swallow count S |
| ld_wide | input | 1 | 1 = 10-bit M, 0 = 9-bit M (bit 9 ignored) |
| out_pulse | output | 1 | Single-cycle pulse once per 32·M+S ticks |

## Verification
Two events can fall in the same cycle: a shadow load and the terminal reload of the counters. The bench provokes this by raising the load strobe on exactly the tick that ends a period. It then checks that the following period still has the old length and that the period after it has the new length. Period lengths are measured in ticks against 32·M+S, computed arithmetically. The sweep covers every S and includes narrow masking, clamping and gapped tick patterns.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int unsigned DEF_SW_W = 5;
  localparam int unsigned DEF_M_W  = 10;

  typedef enum logic {
    SPAN_NARROW = 1'b0,
    SPAN_WIDE   = 1'b1
  } span_e;
endpackage

// File: rtl/pss_shadow.sv
module pss_shadow #(
  parameter int unsigned SW_W = pss_pkg::DEF_SW_W,
  parameter int unsigned M_W  = pss_pkg::DEF_M_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_stb,
  input  logic [M_W-1:0]  ld_m,
  input  logic [SW_W-1:0] ld_s,
  input  logic            ld_wide,
  output logic [M_W-1:0]  sh_m,
  output logic [SW_W-1:0] sh_s
);
  import pss_pkg::*;
  localparam int unsigned M_FLOOR = 2 ** SW_W;

  span_e          span;
  logic [M_W-1:0] m_masked;
  logic [M_W-1:0] m_clamped;

  assign span = span_e'(ld_wide);

  always_comb begin
    m_masked = ld_m;
    if (span == SPAN_NARROW) m_masked[M_W-1] = 1'b0;
    m_clamped = (m_masked < M_W'(M_FLOOR)) ? M_W'(M_FLOOR) : m_masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_m <= M_W'(M_FLOOR);
      sh_s <= '0;
    end else if (ld_stb) begin
      sh_m <= m_clamped;
      sh_s <= ld_s;
    end
  end

  // R6: the stored ratio never drops below the floor
  assert_m_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sh_m >= M_W'(M_FLOOR));

  // R7: settings move only on a strobe
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stb |=> $stable({sh_m, sh_s}));

  // R4: a narrow load leaves the top bit clear
  assert_narrow_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && !ld_wide) |=> !sh_m[M_W-1]);
endmodule

// File: rtl/pss_prescaler.sv
module pss_prescaler #(
  parameter int unsigned SW_W = pss_pkg::DEF_SW_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_tick,
  input  logic swallow_live,
  output logic pre_done
);
  localparam int unsigned PC_W  = SW_W + 1;
  localparam int unsigned BASE  = 2 ** SW_W;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last_idx;

  assign last_idx = swallow_live ? PC_W'(BASE) : PC_W'(BASE - 1);
  assign pre_done = in_tick && (pc_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= '0;
    else if (pre_done) pc_q <= '0;
    else if (in_tick)  pc_q <= pc_q + 1'b1;
  end

  // R3: the sub-cycle count never passes the longer modulus
  assert_pre_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= PC_W'(BASE));

  // R3: the 33rd position is only reached while swallowing
  assert_long_only_swallow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q == PC_W'(BASE)) |-> swallow_live);

  // R9: no tick, no movement
  assert_pre_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tick |=> $stable(pc_q));
endmodule

// File: rtl/pss_swallow.sv
module pss_swallow #(
  parameter int unsigned SW_W = pss_pkg::DEF_SW_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_done,
  input  logic            reload,
  input  logic [SW_W-1:0] s_load,
  output logic [SW_W-1:0] sw_q,
  output logic            live
);
  assign live = (sw_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sw_q <= '0;
    else if (reload)           sw_q <= s_load;
    else if (pre_done && live) sw_q <= sw_q - 1'b1;
  end

  // R9: the swallow count holds between prescaler completions
  assert_sw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_done && !reload) |=> $stable(sw_q));
endmodule

// File: rtl/pss_main.sv
module pss_main #(
  parameter int unsigned M_W = pss_pkg::DEF_M_W,
  parameter int unsigned SW_W = pss_pkg::DEF_SW_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_done,
  input  logic [M_W-1:0] m_load,
  output logic [M_W-1:0] mc_q,
  output logic           wrap
);
  localparam int unsigned M_FLOOR = 2 ** SW_W;

  assign wrap = pre_done && (mc_q == M_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mc_q <= M_W'(M_FLOOR);
    else if (wrap)     mc_q <= m_load;
    else if (pre_done) mc_q <= mc_q - 1'b1;
  end

  // R2: the main count never underflows to zero
  assert_mc_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mc_q != '0);

  // R9: the main count holds between prescaler completions
  assert_mc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_done |=> $stable(mc_q));
endmodule

// File: rtl/pss_divider.sv
module pss_divider #(
  parameter int unsigned SW_W = pss_pkg::DEF_SW_W,
  parameter int unsigned M_W  = pss_pkg::DEF_M_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_tick,
  input  logic            ld_stb,
  input  logic [M_W-1:0]  ld_m,
  input  logic [SW_W-1:0] ld_s,
  input  logic            ld_wide,
  output logic            out_pulse
);
  logic [M_W-1:0]  sh_m;
  logic [SW_W-1:0] sh_s;
  logic [SW_W-1:0] sw_q;
  logic [M_W-1:0]  mc_q;
  logic            live;
  logic            pre_done;
  logic            wrap;

  pss_shadow #(.SW_W(SW_W), .M_W(M_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_m(ld_m), .ld_s(ld_s),
    .ld_wide(ld_wide), .sh_m(sh_m), .sh_s(sh_s)
  );

  pss_prescaler #(.SW_W(SW_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .in_tick(in_tick), .swallow_live(live),
    .pre_done(pre_done)
  );

  pss_swallow #(.SW_W(SW_W)) u_swallow (
    .clk(clk), .rst_n(rst_n), .pre_done(pre_done), .reload(wrap),
    .s_load(sh_s), .sw_q(sw_q), .live(live)
  );

  pss_main #(.M_W(M_W), .SW_W(SW_W)) u_main (
    .clk(clk), .rst_n(rst_n), .pre_done(pre_done), .m_load(sh_m),
    .mc_q(mc_q), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_pulse <= 1'b0;
    else        out_pulse <= wrap;
  end

  // R10: the output pulse lasts one cycle
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_pulse |=> !out_pulse);

  // R3: swallowing always finishes inside one main period
  assert_swallow_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    M_W'(sw_q) <= mc_q);

  // R2: a period ends only on a tick
  assert_wrap_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tick |=> !out_pulse);
endmodule

// File: tb/pss_divider_tb.sv
`timescale 1ns/1ps
module pss_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_tick = 1'b0;
  logic       ld_stb = 1'b0;
  logic [9:0] ld_m = '0;
  logic [4:0] ld_s = '0;
  logic       ld_wide = 1'b0;
  logic       out_pulse;

  int vec = 0;
  int bad = 0;
  int act_n;
  int sh_n;
  bit done = 0;

  always #2 clk = ~clk;

  pss_divider u_dut (
    .clk(clk), .rst_n(rst_n), .in_tick(in_tick), .ld_stb(ld_stb),
    .ld_m(ld_m), .ld_s(ld_s), .ld_wide(ld_wide), .out_pulse(out_pulse)
  );

  function automatic int ratio_of(int m, int s, bit wide);
    int me;
    me = wide ? (m % 1024) : (m % 512);
    if (me < 32) me = 32;
    return 32 * me + s;
  endfunction

  task automatic run_period(string tag, bit do_ld, bit late, int m, int s,
                            bit wide, bit gap);
    int cnt = 0;
    int seen = 0;
    int cyc = 0;
    int target = act_n;
    bit t;
    while (cnt < target) begin
      @(negedge clk);
      t = gap ? ((cyc % 2) == 0) : 1'b1;
      cyc++;
      in_tick = t;
      ld_stb = do_ld && t && ((late && cnt == target - 1) || (!late && cnt == 0));
      ld_m = 10'(m);
      ld_s = 5'(s);
      ld_wide = wide;
      @(posedge clk);
      #1;
      if (t) cnt++;
      if (out_pulse && seen == 0) seen = cnt;
    end
    @(negedge clk);
    in_tick = 1'b0;
    ld_stb = 1'b0;
    vec++;
    if (seen != target) begin
      bad++;
      $display("FAIL %s: pulse after tick %0d, expected %0d", tag, seen, target);
    end
    if (do_ld && !late) sh_n = ratio_of(m, s, wide);
    act_n = sh_n;
    if (do_ld && late) sh_n = ratio_of(m, s, wide);
  endtask

  // R10 / R9: an idle cycle right after a pulse keeps the output low
  task automatic idle_check(string tag);
    @(posedge clk);
    #1;
    vec++;
    if (out_pulse !== 1'b0) begin
      bad++;
      $display("FAIL %s: out_pulse=%0b expected 0", tag, out_pulse);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    act_n = 1024;
    sh_n = 1024;
    repeat (5) @(posedge clk);
    #1;
    vec++;
    if (out_pulse !== 1'b0) begin
      bad++;
      $display("FAIL R1: out_pulse=%0b in reset expected 0", out_pulse);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: default period of 1024 ticks
    run_period("R1", 0, 0, 0, 0, 1, 0);
    idle_check("R10");

    // R2 / R3 / R7: sweep every S at M=32; each load governs the next period
    for (int s = 0; s < 32; s++) run_period("R3", 1, 0, 32, s, 1, 0);
    run_period("R2", 1, 0, 33, 31, 1, 0);
    idle_check("R10");

    // R5: full 10-bit span at the top of the range
    run_period("R7", 1, 0, 1023, 31, 1, 0);
    run_period("R5", 1, 0, 545, 2, 1, 0);

    // R4: narrow span drops bit 9 (0x221 -> 33)
    run_period("R5", 1, 0, 10'h221, 4, 0, 0);
    run_period("R4", 1, 0, 10'h221, 4, 0, 0);

    // R6: clamping, including after narrow masking (0x210 -> 16 -> 32)
    run_period("R4", 1, 0, 5, 7, 1, 0);
    run_period("R6", 1, 0, 0, 0, 1, 0);
    run_period("R6", 1, 0, 10'h210, 9, 0, 0);
    run_period("R6", 1, 0, 40, 1, 1, 0);

    // R8: load on the period-ending tick; next period keeps old value
    run_period("R6", 1, 1, 34, 3, 1, 0);
    run_period("R8", 0, 0, 0, 0, 1, 0);
    run_period("R8", 0, 0, 0, 0, 1, 0);

    // R9: ticks every other cycle; period still counted in ticks
    run_period("R9", 1, 0, 32, 17, 1, 1);
    run_period("R9", 0, 0, 0, 0, 1, 1);
    idle_check("R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule